// File: doc/BRIEF.md
# SDRAM Command Legality Monitor

This block is a passive observer for a synchronous DRAM command bus. It samples chip select, the three strobe lines, the bank address, the A10 line and the clock enable on every rising clock edge. It keeps a small state machine per bank that follows the bank through opening a row, bursting, closing the row, refreshing and programming the mode register. Each command is checked against the state of the bank or banks it addresses.

When a command is not allowed in the current state, the monitor raises a one-cycle error pulse. The pulse carries the bank, that bank's state and the decoded command. Legal commands advance the bank models. Illegal ones are reported and otherwise dropped, so a single fault does not cause a chain of follow-on reports. The block drives no memory signals and models no data. It can sit in a testbench or stay in silicon as a bus checker.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: With clock enable high, the command comes from {ras_n,cas_n,we_n} while cs_n is low: 111 no-op (code 0), 011 activate (1), 101 read (2), 100 write (3), 110 burst stop (4), 010 precharge (5), 001 refresh (6), 000 mode set (7). cs_n high is a deselect and is treated as a no-op. A no-op or deselect never raises an error, whatever the other lines carry.
- R2: In an idle bank (state code 0), activate, precharge and refresh are legal, and activate opens the row. Read, write and burst stop are illegal.
- R3: Refresh and mode set are checked against every bank and are legal only when all banks are idle. Refresh puts every bank in the refreshing state (code 9). Mode set puts every bank in the mode-access state (code 10).
- R4: In a bank with an open row (code 2), read, write, precharge and burst stop are legal. Activate, refresh and mode set are illegal.
- R5: During a plain read (code 3) or write (code 4) burst, a read or write to that bank restarts the burst, burst stop ends it with the row kept open, and precharge closes the row. Activate, refresh and mode set are illegal.
- R6: A10 high on a read or write selects auto-precharge, which gives state 5 for a read and 6 for a write. In these states every command to the bank is illegal. A read burst ends in precharging. A write burst ends in write recovery (code 7) and then precharging.
- R7: In the row-opening (code 1), write-recovery, refreshing and mode-access states, every command to the bank is illegal. While precharging (code 8) only a precharge is accepted, as a no-op.
- R8: Banks are tracked independently, and bank-directed commands use bank address ba. On a precharge, A10 high addresses all banks and A10 low only bank ba.
- R9: Let a timed state be entered at edge X with a duration of N cycles. Commands at edges X+1 to X+N-1 see that state, and the command at edge X+N sees the next state. The durations are T_RCD for row opening, T_RP for precharging, T_RC for refreshing, T_MRD for mode access, T_WR for write recovery and BURST_LEN for any burst. Defaults are 3, 3, 9, 2, 2 and 4.
- R10: An illegal command sampled at edge E raises err_pulse for the cycle after E. err_bank, err_state and err_cmd then hold the offending bank, its state code and the command code. When several banks reject the same command, the lowest-numbered bank is reported. All fields are zero when there is no error.
- R11: An illegal command changes no bank's state. Timers keep running.
- R12: A command sampled while cke is low is ignored. It is not checked and does not change any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge samples |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable; low suppresses command sampling |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| a10 | input | 1 | Auto-precharge / all-bank select |
| err_pulse | output | 1 | One-cycle illegal-command flag |
| err_bank | output | BA_W | Bank that rejected the command |
| err_state | output | 4 | State code of that bank |
| err_cmd | output | 3 | Command code that was rejected |

## Verification
The bench probes the edges of each timed window by placing commands on the last cycle of a state and on the first cycle of its successor. A model that is off by one cycle would flag a legal command or accept an illegal one there. It sends an all-bank precharge while one bank is still opening and then reads the other bank. A monitor that applied a rejected command would report that read as a read to a precharging bank. It also uses a refresh-time mode set to check that the lowest rejecting bank is reported. Further cases cover auto-precharge bursts that end into recovery and precharge, deselects with an all-low strobe pattern, and commands sent while clock enable is low. Designs that decode these wrongly produce errors the bench does not expect.

// File: rtl/sdram_mon_pkg.sv
// Shared command and bank-state encodings for the SDRAM command monitor.
// Assumes: code values are visible at the error port and must stay fixed.
package sdram_mon_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_BST = 3'd4,
        CMD_PRE = 3'd5,
        CMD_REF = 3'd6,
        CMD_MRS = 3'd7
    } cmd_e;

    typedef enum logic [3:0] {
        ST_IDLE = 4'd0,
        ST_ACTV = 4'd1,
        ST_OPEN = 4'd2,
        ST_RD   = 4'd3,
        ST_WR   = 4'd4,
        ST_RDA  = 4'd5,
        ST_WRA  = 4'd6,
        ST_WREC = 4'd7,
        ST_PRE  = 4'd8,
        ST_REF  = 4'd9,
        ST_MRS  = 4'd10
    } bank_st_e;

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
// Turns the raw strobe lines into a command code and a mask of addressed banks.
// Assumes: cke low or cs_n high means no command; all-bank commands set every mask bit.
module sdram_cmd_decode
    import sdram_mon_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    localparam int BA_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                 cke,
    input  logic                 cs_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic [BA_W-1:0]      ba,
    input  logic                 a10,
    output cmd_e                 op_o,
    output logic [NUM_BANKS-1:0] target_o
);

    logic [NUM_BANKS-1:0] one_bank;

    // Command code from the strobe pattern
    always_comb begin
        op_o = CMD_NOP;
        if (cke && !cs_n) begin
            unique case ({ras_n, cas_n, we_n})
                3'b111:  op_o = CMD_NOP;
                3'b011:  op_o = CMD_ACT;
                3'b101:  op_o = CMD_RD;
                3'b100:  op_o = CMD_WR;
                3'b110:  op_o = CMD_BST;
                3'b010:  op_o = CMD_PRE;
                3'b001:  op_o = CMD_REF;
                default: op_o = CMD_MRS;
            endcase
        end
    end

    assign one_bank = NUM_BANKS'(1) << ba;

    // Which banks the command must be checked against
    always_comb begin
        unique case (op_o)
            CMD_NOP:          target_o = '0;
            CMD_REF, CMD_MRS: target_o = '1;
            CMD_PRE:          target_o = a10 ? '1 : one_bank;
            default:          target_o = one_bank;
        endcase
    end

endmodule

// File: rtl/sdram_bank_tracker.sv
// Follows one bank through its command states and judges each command aimed at it.
// Assumes: every duration parameter is at least 2; apply_i is low whenever
// any bank rejected the current command, so rejected commands change nothing.
module sdram_bank_tracker
    import sdram_mon_pkg::*;
#(
    parameter int BURST_LEN = 4,
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int T_RC      = 9,
    parameter int T_WR      = 2,
    parameter int T_MRD     = 2,
    localparam int LONGEST  = max_of(max_of(max_of(T_RCD, T_RP), max_of(T_RC, T_MRD)),
                                     max_of(T_WR, BURST_LEN)),
    localparam int CNT_W    = $clog2(LONGEST + 1)
) (
    input  logic     clk,
    input  logic     rst_n,
    input  cmd_e     op_i,
    input  logic     hit_i,
    input  logic     auto_pre_i,
    input  logic     apply_i,
    output bank_st_e state_o,
    output logic     illegal_o
);

    bank_st_e         state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic             bad;

    // Legality of the current command in the current state
    always_comb begin
        unique case (state)
            ST_IDLE:               bad = (op_i == CMD_RD) || (op_i == CMD_WR) || (op_i == CMD_BST);
            ST_OPEN, ST_RD, ST_WR: bad = (op_i == CMD_ACT) || (op_i == CMD_REF) || (op_i == CMD_MRS);
            ST_PRE:                bad = (op_i != CMD_NOP) && (op_i != CMD_PRE);
            default:               bad = (op_i != CMD_NOP);
        endcase
    end

    assign illegal_o = hit_i && bad;

    // Next state: timer expiry first, then an accepted command overrides it
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        if (state != ST_IDLE && state != ST_OPEN) begin
            if (cnt == CNT_W'(1)) begin
                unique case (state)
                    ST_RDA:  begin state_nx = ST_PRE;  cnt_nx = CNT_W'(T_RP - 1); end
                    ST_WRA:  begin state_nx = ST_WREC; cnt_nx = CNT_W'(T_WR - 1); end
                    ST_WREC: begin state_nx = ST_PRE;  cnt_nx = CNT_W'(T_RP - 1); end
                    ST_ACTV, ST_RD, ST_WR: state_nx = ST_OPEN;
                    default: state_nx = ST_IDLE;
                endcase
            end else begin
                cnt_nx = cnt - CNT_W'(1);
            end
        end
        if (hit_i && apply_i) begin
            unique case (op_i)
                CMD_ACT: begin state_nx = ST_ACTV; cnt_nx = CNT_W'(T_RCD - 1); end
                CMD_RD:  begin state_nx = auto_pre_i ? ST_RDA : ST_RD; cnt_nx = CNT_W'(BURST_LEN - 1); end
                CMD_WR:  begin state_nx = auto_pre_i ? ST_WRA : ST_WR; cnt_nx = CNT_W'(BURST_LEN - 1); end
                CMD_BST: if (state == ST_RD || state == ST_WR) state_nx = ST_OPEN;
                CMD_PRE: if (state == ST_OPEN || state == ST_RD || state == ST_WR) begin
                             state_nx = ST_PRE; cnt_nx = CNT_W'(T_RP - 1);
                         end
                CMD_REF: begin state_nx = ST_REF; cnt_nx = CNT_W'(T_RC - 1); end
                CMD_MRS: begin state_nx = ST_MRS; cnt_nx = CNT_W'(T_MRD - 1); end
                default: ;
            endcase
        end
    end

    // State and timer registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    assign state_o = state;

    // R2
    idle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> (state == ST_IDLE || state == ST_ACTV || state == ST_REF || state == ST_MRS));

    // R6
    rda_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RDA) |=> (state == ST_RDA || state == ST_PRE));

    // R6
    wra_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRA) |=> (state == ST_WRA || state == ST_WREC));

    // R7
    pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRE) |=> (state == ST_PRE || state == ST_IDLE));

endmodule

// File: rtl/sdram_err_report.sv
// Picks the lowest bank that rejected the command and registers the error record.
// Assumes: illegal_i and st_i are combinational from the same sampled command.
module sdram_err_report #(
    parameter int NUM_BANKS = 2,
    localparam int BA_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_BANKS-1:0]       illegal_i,
    input  logic [NUM_BANKS-1:0][3:0]  st_i,
    input  logic [2:0]                 op_i,
    output logic                       err_pulse,
    output logic [BA_W-1:0]            err_bank,
    output logic [3:0]                 err_state,
    output logic [2:0]                 err_cmd
);

    logic [BA_W-1:0] pick;
    logic            found;

    // Lowest-numbered rejecting bank wins
    always_comb begin
        pick = '0;
        for (int i = NUM_BANKS - 1; i >= 0; i--) begin
            if (illegal_i[i]) pick = BA_W'(i);
        end
        found = |illegal_i;
    end

    // One-cycle registered error record
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_pulse <= 1'b0;
            err_bank  <= '0;
            err_state <= '0;
            err_cmd   <= '0;
        end else begin
            err_pulse <= found;
            err_bank  <= found ? pick : '0;
            err_state <= found ? st_i[pick] : 4'd0;
            err_cmd   <= found ? op_i : 3'd0;
        end
    end

endmodule

// File: rtl/sdram_cmd_monitor.sv
// Top of the SDRAM command legality monitor: decodes the bus, keeps one state
// model per bank and reports rejected commands.
// Assumes: passive use only; rejected commands are dropped from all bank models.
module sdram_cmd_monitor
    import sdram_mon_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int BURST_LEN = 4,
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int T_RC      = 9,
    parameter int T_WR      = 2,
    parameter int T_MRD     = 2,
    localparam int BA_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cke,
    input  logic            cs_n,
    input  logic            ras_n,
    input  logic            cas_n,
    input  logic            we_n,
    input  logic [BA_W-1:0] ba,
    input  logic            a10,
    output logic            err_pulse,
    output logic [BA_W-1:0] err_bank,
    output logic [3:0]      err_state,
    output logic [2:0]      err_cmd
);

    cmd_e                      op;
    logic [NUM_BANKS-1:0]      target;
    logic [NUM_BANKS-1:0]      illegal;
    logic [NUM_BANKS-1:0][3:0] bank_st;
    logic                      apply;

    sdram_cmd_decode #(.NUM_BANKS(NUM_BANKS)) u_decode (
        .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .a10(a10), .op_o(op), .target_o(target)
    );

    // A command is applied only if no bank rejects it
    assign apply = ~|illegal;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        bank_st_e st;
        sdram_bank_tracker #(
            .BURST_LEN(BURST_LEN), .T_RCD(T_RCD), .T_RP(T_RP),
            .T_RC(T_RC), .T_WR(T_WR), .T_MRD(T_MRD)
        ) u_bank (
            .clk(clk), .rst_n(rst_n), .op_i(op), .hit_i(target[g]),
            .auto_pre_i(a10), .apply_i(apply), .state_o(st), .illegal_o(illegal[g])
        );
        assign bank_st[g] = st;
    end

    for (genvar g = 1; g < NUM_BANKS; g++) begin : g_lockstep
        // R3
        refresh_lockstep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bank_st[0] == ST_REF) |-> (bank_st[g] == ST_REF));
    end

    sdram_err_report #(.NUM_BANKS(NUM_BANKS)) u_report (
        .clk(clk), .rst_n(rst_n), .illegal_i(illegal), .st_i(bank_st), .op_i(op),
        .err_pulse(err_pulse), .err_bank(err_bank), .err_state(err_state), .err_cmd(err_cmd)
    );

    // R1
    nop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || (ras_n && cas_n && we_n)) |=> !err_pulse);

    // R12
    cke_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |=> !err_pulse);

endmodule

// File: tb/sdram_cmd_monitor_tb.sv
// Directed bench for the SDRAM command monitor: one task per scenario.
module sdram_cmd_monitor_tb;

    localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3,
                           C_BST = 3'd4, C_PRE = 3'd5, C_REF = 3'd6, C_MRS = 3'd7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cke = 1'b1, cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0;
    logic [0:0] ba = '0;
    logic       err_pulse;
    logic [0:0] err_bank;
    logic [3:0] err_state;
    logic [2:0] err_cmd;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    sdram_cmd_monitor u_dut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .a10(a10), .err_pulse(err_pulse), .err_bank(err_bank),
        .err_state(err_state), .err_cmd(err_cmd)
    );

    task automatic check(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] c, input int b, input logic a);
        cs_n = 1'b0;
        ba   = b[0:0];
        a10  = a;
        unique case (c)
            C_NOP: {ras_n, cas_n, we_n} = 3'b111;
            C_ACT: {ras_n, cas_n, we_n} = 3'b011;
            C_RD:  {ras_n, cas_n, we_n} = 3'b101;
            C_WR:  {ras_n, cas_n, we_n} = 3'b100;
            C_BST: {ras_n, cas_n, we_n} = 3'b110;
            C_PRE: {ras_n, cas_n, we_n} = 3'b010;
            C_REF: {ras_n, cas_n, we_n} = 3'b001;
            default: {ras_n, cas_n, we_n} = 3'b000;
        endcase
    endtask

    // One command on one edge, then its error record checked
    task automatic cmd(input logic [2:0] c, input int b, input logic a, input logic exp_e,
                       input int eb, input logic [3:0] es, input string tag);
        drive(c, b, a);
        @(negedge clk);
        drive(C_NOP, 0, 1'b0);
        if (exp_e)
            check(err_pulse && err_bank == eb[0:0] && err_state == es && err_cmd == c, tag,
                  {4'(err_pulse), 4'(err_bank), err_state, 1'b0, err_cmd},
                  {4'd1, 4'(eb), es, 1'b0, c});
        else
            check(!err_pulse, tag, 16'(err_pulse), 16'd0);
    endtask

    task automatic nop(input int n);
        for (int i = 0; i < n; i++) begin
            drive(C_NOP, 0, 1'b0);
            @(negedge clk);
            check(!err_pulse, "R1 no-op quiet", 16'(err_pulse), 16'd0);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cke = 1'b1;
        drive(C_NOP, 0, 1'b0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        check(!err_pulse && err_state == 0 && err_cmd == 0, "R10 reset record zero",
              {4'(err_pulse), err_state, 5'd0, err_cmd}, 16'd0);
        cmd(C_MRS, 0, 0, 0, 0, 0, "R3 mode set from all idle");
        nop(1);
    endtask

    task automatic t_idle();
        do_reset();
        cmd(C_RD,  0, 0, 1, 0, 0, "R2 read in idle");
        nop(1);
        cmd(C_WR,  1, 0, 1, 1, 0, "R2 write in idle bank1");
        cmd(C_BST, 0, 0, 1, 0, 0, "R2 burst stop in idle");
        cmd(C_PRE, 0, 0, 0, 0, 0, "R2 precharge in idle");
        cmd(C_PRE, 0, 1, 0, 0, 0, "R8 precharge all in idle");
        cmd(C_ACT, 0, 0, 0, 0, 0, "R2 activate in idle");
    endtask

    task automatic t_activate();
        do_reset();
        cmd(C_ACT, 0, 0, 0, 0, 0, "R2 activate");
        cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b000;
        @(negedge clk);
        drive(C_NOP, 0, 1'b0);
        check(!err_pulse, "R1 deselect ignored", 16'(err_pulse), 16'd0);
        cmd(C_RD, 0, 0, 1, 0, 1, "R7 read while opening, last cycle");
        cmd(C_RD, 0, 0, 0, 0, 0, "R9 read after T_RCD");
    endtask

    task automatic t_row_open();
        do_reset();
        cmd(C_ACT, 0, 0, 0, 0, 0, "R2 activate");
        nop(2);
        cmd(C_ACT, 0, 0, 1, 0, 2, "R4 activate on open row");
        cmd(C_REF, 0, 0, 1, 0, 2, "R4 refresh with open row");
        cmd(C_BST, 0, 0, 0, 0, 0, "R4 burst stop on open row");
        cmd(C_PRE, 0, 0, 0, 0, 0, "R4 precharge open row");
        cmd(C_RD,  0, 0, 1, 0, 8, "R7 read while precharging");
    endtask

    task automatic t_burst();
        do_reset();
        cmd(C_ACT, 0, 0, 0, 0, 0, "R2 activate");
        nop(2);
        cmd(C_RD,  0, 0, 0, 0, 0, "R4 read on open row");
        cmd(C_ACT, 0, 0, 1, 0, 3, "R5 activate during read");
        cmd(C_WR,  0, 0, 0, 0, 0, "R5 write interrupts read");
        cmd(C_BST, 0, 0, 0, 0, 0, "R5 burst stop in write");
        cmd(C_ACT, 0, 0, 1, 0, 2, "R5 row open after burst stop");
        cmd(C_RD,  0, 0, 0, 0, 0, "R4 read again");
        nop(3);
        cmd(C_ACT, 0, 0, 1, 0, 2, "R9 burst over after BURST_LEN");
        cmd(C_PRE, 0, 0, 0, 0, 0, "R4 precharge");
        cmd(C_RD,  0, 0, 1, 0, 8, "R7 read while precharging");
        cmd(C_PRE, 0, 0, 0, 0, 0, "R7 precharge while precharging");
        cmd(C_ACT, 0, 0, 0, 0, 0, "R9 idle after T_RP");
    endtask

    task automatic t_read_ap();
        do_reset();
        cmd(C_ACT, 0, 0, 0, 0, 0, "R2 activate");
        nop(2);
        cmd(C_RD,  0, 1, 0, 0, 0, "R6 read with auto-precharge");
        cmd(C_RD,  0, 0, 1, 0, 5, "R6 read during auto-precharge read");
        cmd(C_PRE, 0, 0, 1, 0, 5, "R6 precharge during auto-precharge read");
        cmd(C_BST, 0, 0, 1, 0, 5, "R6 burst stop during auto-precharge read");
        cmd(C_ACT, 0, 0, 1, 0, 8, "R6 burst ends into precharge");
        cmd(C_ACT, 0, 0, 1, 0, 8, "R9 precharge last cycle");
        cmd(C_ACT, 0, 0, 0, 0, 0, "R9 idle after auto precharge");
    endtask

    task automatic t_write_ap();
        do_reset();
        cmd(C_ACT, 0, 0, 0, 0, 0, "R2 activate");
        nop(2);
        cmd(C_WR,  0, 1, 0, 0, 0, "R6 write with auto-precharge");
        cmd(C_WR,  0, 0, 1, 0, 6, "R6 write during auto-precharge write");
        nop(1);
        cmd(C_REF, 0, 0, 1, 0, 6, "R6 refresh on last burst cycle");
        cmd(C_REF, 0, 0, 1, 0, 7, "R6 write recovery after burst");
        cmd(C_ACT, 0, 0, 1, 0, 8, "R6 precharge after recovery");
        nop(1);
        cmd(C_MRS, 0, 0, 0, 0, 0, "R9 idle after recovery and T_RP");
    endtask

    task automatic t_banks();
        do_reset();
        cmd(C_ACT, 0, 0, 0, 0, 0, "R8 activate bank0");
        cmd(C_ACT, 1, 0, 0, 0, 0, "R8 activate bank1 independently");
        nop(1);
        cmd(C_PRE, 0, 1, 1, 1, 1, "R8 precharge all hits opening bank1");
        cmd(C_RD,  0, 0, 0, 0, 0, "R11 rejected precharge left bank0 open");
        cmd(C_PRE, 1, 0, 0, 0, 0, "R8 single-bank precharge bank1");
        cmd(C_RD,  0, 0, 0, 0, 0, "R8 bank0 unaffected by bank1 precharge");
        cmd(C_RD,  1, 0, 1, 1, 8, "R8 bank1 precharging");
    endtask

    task automatic t_refresh();
        do_reset();
        cmd(C_REF, 0, 0, 0, 0, 0, "R3 refresh from all idle");
        cmd(C_ACT, 1, 0, 1, 1, 9, "R3 bank1 refreshing");
        cmd(C_MRS, 0, 0, 1, 0, 9, "R10 lowest bank reported");
        nop(6);
        cmd(C_ACT, 0, 0, 0, 0, 0, "R9 idle after T_RC");
        cmd(C_MRS, 0, 0, 1, 0, 1, "R3 mode set with bank not idle");
        do_reset();
        cmd(C_MRS, 0, 0, 0, 0, 0, "R3 mode set");
        cmd(C_ACT, 0, 0, 1, 0, 10, "R7 activate during mode access");
        cmd(C_ACT, 0, 0, 0, 0, 0, "R9 idle after T_MRD");
    endtask

    task automatic t_cke();
        do_reset();
        cke = 1'b0;
        cmd(C_RD,  0, 0, 0, 0, 0, "R12 read ignored with cke low");
        cmd(C_ACT, 0, 0, 0, 0, 0, "R12 activate ignored with cke low");
        nop(2);
        cke = 1'b1;
        cmd(C_RD,  0, 0, 1, 0, 0, "R12 bank still idle");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_idle();
        t_activate();
        t_row_open();
        t_burst();
        t_read_ap();
        t_write_ap();
        t_banks();
        t_refresh();
        t_cke();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule